// File: doc/BRIEF.md
# Serial Destination-Address Filter

This block sits beside an Ethernet receiver and listens to the decoded serial receive stream. It takes NRZ data and a recovered bit clock, and that clock runs only while a frame is arriving. Both are brought into a free-running system-clock domain. The block waits out the alternating preamble and recognises the start-of-frame delimiter. It then marks every byte boundary and presents each received byte in parallel form.

The first six bytes after the delimiter form the destination address. Once the sixth byte is in, the address is compared against a small table of 48-bit entries. Each entry has its own valid bit, and the table is loaded through a synchronous write port. A mode input selects the sense of the decision: reject frames whose address misses the table, or reject frames whose address hits it. A reject is signalled by driving an active-low line for a fixed number of system clocks, long enough to meet a 200 ns minimum. The decision always falls well inside the 64-byte window that follows the delimiter.

When the bit clock has been silent for a set number of system clocks, the frame is taken as finished. The block then returns to hunting and throws away any partial byte.

Top module: `eadr_filter`

## Requirements
- R1: The marker output `mark_o` pulses exactly once when the last eight received bits, in arrival order, are 1,0,1,0,1,0,1,1. An alternating preamble alone never raises `mark_o` or `byte_vld_o`.
- R2: After the delimiter, every eighth bit raises `mark_o` and `byte_vld_o` together for one clock. `byte_o` carries the byte with the first-arriving bit in bit 0.
- R3: The first six bytes after the delimiter form the address, with the first byte in bits [7:0]. They are compared once against the table after the sixth byte completes.
- R4: With `rej_on_hit_i` = 0, a frame is rejected when no valid entry equals its address. With `rej_on_hit_i` = 1, a frame is rejected when a valid entry equals its address. Otherwise there is no reject.
- R5: Each reject drives `reject_no` low for exactly REJ_CYC system clocks, which is 25 clocks (200 ns at 125 MHz) by default. A frame produces at most one reject pulse.
- R6: A reject pulse begins after the sixth byte and before byte WIN_BYTES (64) after the delimiter has been delivered.
- R7: An entry whose valid bit is 0 never matches, even when its stored address is equal.
- R8: After IDLE_CYC system clocks with no bit-clock edge, the block returns to hunting and discards any partial byte and byte count. Later bits produce no marker until a fresh delimiter arrives, and the first byte of the next frame is assembled cleanly.
- R9: During reset, `reject_no` is 1, and `mark_o` and `byte_vld_o` are 0.
- R10: A write with `tab_we_i` = 1 stores `tab_mac_i` and `tab_vld_i` at entry `tab_idx_i`. Every compare made after that write uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_clk_i | input | 1 | Recovered receive bit clock; runs only during a frame |
| rx_dat_i | input | 1 | NRZ receive data, valid at the rising edge of rx_clk_i |
| tab_we_i | input | 1 | Table write strobe |
| tab_idx_i | input | clog2(NENT) | Table entry index |
| tab_mac_i | input | 48 | Address to store |
| tab_vld_i | input | 1 | Valid bit to store |
| rej_on_hit_i | input | 1 | 0: reject on miss; 1: reject on hit |
| mark_o | output | 1 | Delimiter and byte-boundary strobe |
| byte_o | output | 8 | Last assembled byte |
| byte_vld_o | output | 1 | byte_o is new this clock |
| reject_no | output | 1 | Active-low reject pulse |

## Verification
A stuck hunt state shows up at the ports within one byte time. Either no marker appears after the delimiter, or markers appear during the preamble. A bit-counter or shift error corrupts the very first `byte_o` after the delimiter. Stale state left after an abandoned frame shows in the first byte of the next frame. A faulty table or mode decision shows about two clocks after the sixth byte, as a missing, extra or misplaced fall of `reject_no`. A wrong pulse counter is visible as a low width other than REJ_CYC.

// File: rtl/eadr_pkg.sv
`timescale 1ns/1ps
package eadr_pkg;
   localparam int BYTE_W   = 8;
   localparam int MAC_W    = 48;
   localparam int DA_BYTES = MAC_W / BYTE_W;
   // delimiter in arrival order, oldest bit in the MSB
   localparam logic [BYTE_W-1:0] SFD_PAT = 8'b1010_1011;

   typedef enum logic {ST_HUNT, ST_DATA} hunt_st_e;
endpackage

// File: rtl/eadr_sync.sv
`timescale 1ns/1ps
module eadr_sync #(
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_CYC    = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_clk_i,
   input  logic rx_dat_i,
   output logic bit_v_o,
   output logic bit_d_o,
   output logic idle_o
);
   localparam int GW = $clog2(IDLE_CYC + 1);
   localparam logic [GW-1:0] GAP_MAX = GW'(IDLE_CYC);
   localparam logic [GW-1:0] GAP_HIT = GW'(IDLE_CYC - 1);

   logic [SYNC_STAGES:0]   ck_q;
   logic [SYNC_STAGES-1:0] dq_q;
   logic [GW-1:0]          gap_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ck_q  <= '0;
         dq_q  <= '0;
         gap_q <= GAP_MAX;
      end else begin
         ck_q <= {ck_q[SYNC_STAGES-1:0], rx_clk_i};
         dq_q <= {dq_q[SYNC_STAGES-2:0], rx_dat_i};
         if (bit_v_o)               gap_q <= '0;
         else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
      end
   end

   // data and clock pass through equal depth, so stage SYNC_STAGES-1 lines up
   assign bit_v_o = ck_q[SYNC_STAGES-1] & ~ck_q[SYNC_STAGES];
   assign bit_d_o = dq_q[SYNC_STAGES-1];
   assign idle_o  = (gap_q == GAP_HIT) && !bit_v_o;

   p_idle_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_o |=> !idle_o);
endmodule

// File: rtl/eadr_deser.sv
`timescale 1ns/1ps
module eadr_deser
   import eadr_pkg::*;
#(
   parameter int WIN_BYTES = 64,
   parameter int CW        = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bit_v_i,
   input  logic              bit_d_i,
   input  logic              idle_i,
   output logic              mark_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              byte_vld_o,
   output logic [MAC_W-1:0]  da_o,
   output logic              da_vld_o,
   output logic [CW-1:0]     nbytes_o
);
   localparam logic [CW-1:0] CNT_MAX = CW'(WIN_BYTES + 1);
   localparam logic [CW-1:0] DA_C    = CW'(DA_BYTES);

   hunt_st_e          state_q;
   logic [BYTE_W-1:0] hist_q, bsh_q, byte_q;
   logic [2:0]        bcnt_q;
   logic [CW-1:0]     nbytes_q;
   logic [MAC_W-1:0]  da_q;
   logic              mark_q, bvld_q, davld_q;
   logic [BYTE_W-1:0] hist_nx, byte_nx;

   assign hist_nx = {hist_q[BYTE_W-2:0], bit_d_i};
   assign byte_nx = {bit_d_i, bsh_q[BYTE_W-1:1]};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_HUNT; hist_q <= '0; bsh_q <= '0; byte_q <= '0;
         bcnt_q <= '0; nbytes_q <= '0; da_q <= '0;
         mark_q <= 1'b0; bvld_q <= 1'b0; davld_q <= 1'b0;
      end else begin
         mark_q  <= 1'b0;
         bvld_q  <= 1'b0;
         davld_q <= 1'b0;
         if (idle_i) begin
            state_q <= ST_HUNT; hist_q <= '0; bsh_q <= '0;
            bcnt_q <= '0; nbytes_q <= '0;
         end else if (bit_v_i) begin
            unique case (state_q)
               ST_HUNT: begin
                  hist_q <= hist_nx;
                  if (hist_nx == SFD_PAT) begin
                     state_q  <= ST_DATA;
                     mark_q   <= 1'b1;
                     bcnt_q   <= '0;
                     nbytes_q <= '0;
                  end
               end
               ST_DATA: begin
                  bsh_q  <= byte_nx;
                  bcnt_q <= bcnt_q + 1'b1;
                  if (bcnt_q == 3'd7) begin
                     byte_q <= byte_nx;
                     bvld_q <= 1'b1;
                     mark_q <= 1'b1;
                     if (nbytes_q != CNT_MAX) nbytes_q <= nbytes_q + 1'b1;
                     if (nbytes_q < DA_C) da_q <= {byte_nx, da_q[MAC_W-1:BYTE_W]};
                     if (nbytes_q == DA_C - 1'b1) davld_q <= 1'b1;
                  end
               end
               default: state_q <= ST_HUNT;
            endcase
         end
      end
   end

   assign mark_o     = mark_q;
   assign byte_o     = byte_q;
   assign byte_vld_o = bvld_q;
   assign da_o       = da_q;
   assign da_vld_o   = davld_q;
   assign nbytes_o   = nbytes_q;

   p_hunt_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_HUNT) |=> !byte_vld_o);
   p_byte_marked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_vld_o |-> mark_o);
   p_da_on_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      da_vld_o |-> (byte_vld_o && nbytes_o == DA_C));
   p_idle_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_i |=> (state_q == ST_HUNT && bcnt_q == 3'd0 && nbytes_o == '0));
endmodule

// File: rtl/eadr_cam.sv
`timescale 1ns/1ps
module eadr_cam
   import eadr_pkg::*;
#(
   parameter int NENT     = 4,
   parameter int IW       = 2,
   parameter bit CMP_PIPE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [IW-1:0]    idx_i,
   input  logic [MAC_W-1:0] mac_i,
   input  logic             vld_i,
   input  logic [MAC_W-1:0] da_i,
   input  logic             da_vld_i,
   output logic             dec_vld_o,
   output logic             dec_hit_o
);
   logic [MAC_W-1:0] tab_q [NENT];
   logic [NENT-1:0]  val_q;
   logic [NENT-1:0]  hit_vec;

   for (genvar i = 0; i < NENT; i++) begin : g_ent
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            tab_q[i] <= '0;
            val_q[i] <= 1'b0;
         end else if (we_i && idx_i == IW'(i)) begin
            tab_q[i] <= mac_i;
            val_q[i] <= vld_i;
         end
      end
      assign hit_vec[i] = val_q[i] && (tab_q[i] == da_i);
   end

   if (CMP_PIPE) begin : g_pipe
      logic v_q, h_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            v_q <= 1'b0; h_q <= 1'b0;
         end else begin
            v_q <= da_vld_i;
            h_q <= |hit_vec;
         end
      end
      assign dec_vld_o = v_q;
      assign dec_hit_o = h_q;
   end else begin : g_comb
      assign dec_vld_o = da_vld_i;
      assign dec_hit_o = |hit_vec;
   end

   p_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && int'(idx_i) < NENT) |=>
         (val_q[$past(idx_i)] == $past(vld_i) && tab_q[$past(idx_i)] == $past(mac_i)));
endmodule

// File: rtl/eadr_stretch.sv
`timescale 1ns/1ps
module eadr_stretch #(
   parameter int REJ_CYC = 25
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fire_i,
   output logic rej_no
);
   localparam int PW = $clog2(REJ_CYC + 2);
   localparam logic [PW-1:0] LOAD = PW'(REJ_CYC);

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (fire_i)        cnt_q <= LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign rej_no = (cnt_q == '0);

   // independent measure of each low run
   logic [PW-1:0] low_len_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni || rej_no)          low_len_q <= '0;
      else if (low_len_q != '1)       low_len_q <= low_len_q + 1'b1;
   end

   p_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rej_no) |-> (low_len_q == LOAD));
endmodule

// File: rtl/eadr_filter.sv
`timescale 1ns/1ps
module eadr_filter
   import eadr_pkg::*;
#(
   parameter int NENT        = 4,
   parameter int REJ_CYC     = 25,
   parameter int IDLE_CYC    = 64,
   parameter int SYNC_STAGES = 2,
   parameter int WIN_BYTES   = 64,
   parameter bit CMP_PIPE    = 1'b1,
   localparam int IW         = (NENT > 1) ? $clog2(NENT) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rx_clk_i,
   input  logic              rx_dat_i,
   input  logic              tab_we_i,
   input  logic [IW-1:0]     tab_idx_i,
   input  logic [MAC_W-1:0]  tab_mac_i,
   input  logic              tab_vld_i,
   input  logic              rej_on_hit_i,
   output logic              mark_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              byte_vld_o,
   output logic              reject_no
);
   localparam int CW = $clog2(WIN_BYTES + 2);

   if (NENT < 1)             begin : g_bad_nent  $error("NENT must be at least 1");        end
   if (SYNC_STAGES < 2)      begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   if (REJ_CYC < 1)          begin : g_bad_rej   $error("REJ_CYC must be at least 1");     end
   if (IDLE_CYC < 4)         begin : g_bad_idle  $error("IDLE_CYC must be at least 4");    end
   if (WIN_BYTES <= DA_BYTES) begin : g_bad_win  $error("WIN_BYTES must exceed address"); end

   logic bit_v, bit_d, idle;
   logic [MAC_W-1:0] da;
   logic da_vld, dec_vld, dec_hit, fire;
   logic [CW-1:0] nbytes;

   eadr_sync #(.SYNC_STAGES(SYNC_STAGES), .IDLE_CYC(IDLE_CYC)) i_sync (
      .clk_i, .rst_ni, .rx_clk_i, .rx_dat_i,
      .bit_v_o(bit_v), .bit_d_o(bit_d), .idle_o(idle));

   eadr_deser #(.WIN_BYTES(WIN_BYTES), .CW(CW)) i_deser (
      .clk_i, .rst_ni, .bit_v_i(bit_v), .bit_d_i(bit_d), .idle_i(idle),
      .mark_o, .byte_o, .byte_vld_o, .da_o(da), .da_vld_o(da_vld),
      .nbytes_o(nbytes));

   eadr_cam #(.NENT(NENT), .IW(IW), .CMP_PIPE(CMP_PIPE)) i_cam (
      .clk_i, .rst_ni, .we_i(tab_we_i), .idx_i(tab_idx_i), .mac_i(tab_mac_i),
      .vld_i(tab_vld_i), .da_i(da), .da_vld_i(da_vld),
      .dec_vld_o(dec_vld), .dec_hit_o(dec_hit));

   assign fire = dec_vld && (rej_on_hit_i ? dec_hit : !dec_hit);

   eadr_stretch #(.REJ_CYC(REJ_CYC)) i_stretch (
      .clk_i, .rst_ni, .fire_i(fire), .rej_no(reject_no));

   p_fire_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire |=> !reject_no);
   p_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(reject_no) |-> (nbytes >= CW'(DA_BYTES) && nbytes <= CW'(WIN_BYTES)));
endmodule

// File: tb/test_eadr_filter.sv
`timescale 1ns/1ps
module test_eadr_filter;
   localparam int REJ = 25;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_clk = 1'b0, rx_dat = 1'b0;
   logic we = 1'b0, tvld = 1'b0, mode = 1'b0;
   logic [1:0]  tidx = '0;
   logic [47:0] tmac = '0;
   logic mark, bvld, rej_n;
   logic [7:0] byt;

   int total = 0, bad = 0;
   int n_mark = 0, n_byte = 0, n_pulse = 0, low_run = 0, last_w = 0, rej_at = -1;
   logic rej_prev = 1'b1;
   logic [7:0] cap [64];

   always #4 clk = ~clk;

   eadr_filter i_eadr_filter (
      .clk_i(clk), .rst_ni(rst_n), .rx_clk_i(rx_clk), .rx_dat_i(rx_dat),
      .tab_we_i(we), .tab_idx_i(tidx), .tab_mac_i(tmac), .tab_vld_i(tvld),
      .rej_on_hit_i(mode), .mark_o(mark), .byte_o(byt), .byte_vld_o(bvld),
      .reject_no(rej_n));

   // observer, sampled away from the active edge
   always @(negedge clk) begin
      if (mark) n_mark++;
      if (bvld) begin
         if (n_byte < 64) cap[n_byte] = byt;
         n_byte++;
      end
      if (!rej_n) begin
         if (rej_prev) begin n_pulse++; rej_at = n_byte; end
         low_run++;
      end else if (!rej_prev) begin
         last_w = low_run; low_run = 0;
      end
      rej_prev = rej_n;
   end

   // stimulus vectors: {reject-on-hit mode, address, expected reject}
   localparam logic [49:0] VEC [7] = '{
      {1'b0, 48'h665544332211, 1'b0},
      {1'b0, 48'h123456789ABC, 1'b0},
      {1'b0, 48'hDEADBEEF0001, 1'b1},
      {1'b0, 48'h000000000000, 1'b1},
      {1'b1, 48'h0A0B0C0D0E0F, 1'b1},
      {1'b1, 48'h111111111111, 1'b0},
      {1'b1, 48'hDEADBEEF0001, 1'b0}
   };

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      rx_dat = b; #32; rx_clk = 1'b1; #32; rx_clk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int k = 0; k < 8; k++) send_bit(v[k]);
   endtask

   task automatic send_pre(input int n);
      for (int k = 0; k < n; k++) send_bit(k % 2 == 0);
   endtask

   task automatic clr;
      @(posedge clk);
      n_mark = 0; n_byte = 0; n_pulse = 0; last_w = 0; rej_at = -1;
   endtask

   task automatic wr(input logic [1:0] i, input logic [47:0] m, input logic v);
      @(negedge clk); we = 1'b1; tidx = i; tmac = m; tvld = v;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic run_frame(input logic md, input logic [47:0] mac, input logic exp_rej,
                            input string tag);
      int mism;
      clr();
      mode = md;
      send_pre(24);
      send_byte(8'hD5);                       // delimiter, LSB first
      for (int k = 0; k < 6; k++) send_byte(mac[8*k +: 8]);
      for (int j = 0; j < 10; j++) send_byte(8'hA5 ^ 8'(j));
      repeat (150) @(negedge clk);
      chk(n_mark == 17, {tag, " R1 R2 marks"}, n_mark, 17);
      chk(n_byte == 16, {tag, " R2 byte count"}, n_byte, 16);
      mism = 0;
      for (int k = 0; k < 16 && k < n_byte; k++) begin
         if (k < 6 && cap[k] != mac[8*k +: 8]) mism++;
         if (k >= 6 && cap[k] != (8'hA5 ^ 8'(k - 6))) mism++;
      end
      chk(mism == 0, {tag, " R2 R3 byte values"}, mism, 0);
      chk(n_pulse == int'(exp_rej), {tag, " R3 R4 R7 reject count"}, n_pulse, exp_rej);
      if (exp_rej) begin
         chk(last_w == REJ, {tag, " R5 width"}, last_w, REJ);
         chk(rej_at >= 6 && rej_at <= 64, {tag, " R6 window"}, rej_at, 6);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(rej_n == 1'b1, "R9 reject idle", rej_n, 1);
      chk(mark == 1'b0, "R9 mark idle", mark, 0);
      chk(bvld == 1'b0, "R9 byte_vld idle", bvld, 0);
      rst_n = 1'b1;
      wr(2'd0, 48'h665544332211, 1'b1);
      wr(2'd1, 48'h0A0B0C0D0E0F, 1'b1);
      wr(2'd2, 48'hDEADBEEF0001, 1'b0);       // stored but not valid
      wr(2'd3, 48'h123456789ABC, 1'b1);

      for (int i = 0; i < 7; i++)
         run_frame(VEC[i][49], VEC[i][48:1], VEC[i][0], $sformatf("vec%0d", i));

      // R1: preamble only
      clr(); send_pre(40); repeat (150) @(negedge clk);
      chk(n_mark == 0, "R1 preamble no mark", n_mark, 0);
      chk(n_byte == 0, "R1 preamble no byte", n_byte, 0);

      // R8: abandoned frame, then stray bits, then a clean frame
      clr(); mode = 1'b0;
      send_pre(24); send_byte(8'hD5); send_byte(8'h3C);
      for (int k = 0; k < 4; k++) send_bit(1'b1);
      repeat (150) @(negedge clk);
      chk(n_mark == 2, "R8 partial marks", n_mark, 2);
      chk(n_byte == 1 && cap[0] == 8'h3C, "R8 partial byte", cap[0], 8'h3C);
      chk(n_pulse == 0, "R8 no decision", n_pulse, 0);
      clr();
      for (int k = 0; k < 16; k++) send_bit(1'b0);
      repeat (150) @(negedge clk);
      chk(n_mark == 0 && n_byte == 0, "R8 hunt after idle", n_mark + n_byte, 0);
      run_frame(1'b0, 48'h665544332211, 1'b0, "R8 clean frame");

      // R10: make entry 2 valid, address now accepted
      wr(2'd2, 48'hDEADBEEF0001, 1'b1);
      run_frame(1'b0, 48'hDEADBEEF0001, 1'b0, "R10 rewrite valid");
      wr(2'd0, 48'h665544332211, 1'b0);
      run_frame(1'b0, 48'h665544332211, 1'b1, "R10 R7 cleared entry");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule